// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the status and control word of a floating-point unit. Each time the arithmetic unit finishes an operation, it presents five raw exception indications: invalid, divide-by-zero, overflow, underflow and inexact. The controller turns them into per-operation cause bits and sticky flag bits, and compares the fresh causes against the enable bits kept in the same word. On a match it issues a trap request carrying a fixed vector code.

The same word also carries a rounding-mode field and a denormal-flush bit. These are decoded into two control lines for the arithmetic unit. Software loads the word through a write port. Only a fixed set of bits can be stored; every other bit reads back as zero.

An operation marked as an approximation, such as a reciprocal square-root estimate, reports inexact whenever it raises nothing else.

Top module: `fpsc_ctrl`

## Requirements
- R1: After reset the word reads 0x00040000: rounding field (bits 1:0) is 00, the denormal bit (bit 18) is 1, and all cause, flag and enable bits are 0. `trap_o` is 0 and `trap_vec_o` is 0.
- R2: A write stores `wr_data_i & 0x0007FFFF`. Bits 31:19 always read as zero. The new value is visible on `csr_o` in the cycle after the write.
- R3: `rnd_trunc_o` is 1 exactly when bits 1:0 of the word equal 01, which is the round-to-zero code. For every other value it is 0, which means round-to-nearest-even.
- R4: `ftz_o` follows bit 18 of the word.
- R5: On `op_done_i` without a write, the cause field (bits 17:12) is cleared. Then bit 12+k is set for each set raw flag `op_flags_i[k]`. The index k is 0 for inexact, 1 for underflow, 2 for overflow, 3 for divide-by-zero and 4 for invalid. Bit 17, the unimplemented-operation error, ends up 0.
- R6: On that same update, the new five causes are ORed into the sticky flags at bits 6:2, which use the same order. Flags are never cleared by an operation. Enables (bits 11:7), the rounding field and the denormal bit keep their values.
- R7: `trap_o` is 1 for exactly the cycle after an update whose new causes overlap the enables at bits 11:7. In that cycle `trap_vec_o` is 0x120; in every other cycle it is 0.
- R8: When `op_approx_i` accompanies an update and no raw flag is set, the inexact cause is set. When any raw flag is set, only the raw flags are recorded.
- R9: If a write and `op_done_i` occur in the same cycle, only the write takes effect, and no trap is raised.
- R10: In a cycle with neither a write nor `op_done_i`, the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 32 | Write data |
| op_done_i | input | 1 | Operation-complete strobe |
| op_flags_i | input | 5 | Raw exception flags {V,Z,O,U,I} |
| op_approx_i | input | 1 | Completing operation is an approximation |
| csr_o | output | 32 | Current status word |
| rnd_trunc_o | output | 1 | 1 = truncate, 0 = round to nearest even |
| ftz_o | output | 1 | Flush denormals to zero |
| trap_o | output | 1 | Trap request pulse |
| trap_vec_o | output | 12 | Trap vector code, valid with trap_o |

## Verification
A register write and an operation update can arrive in the same cycle. The bench provokes this by raising a flag whose enable is set while it writes a different word. It then expects exactly the written word, unchanged causes and flags, and no trap pulse in the following cycle. A second collision leaves an enabled trap pending against a write that clears the enables. This confirms that the dropped update does not reach the trap logic by any other path.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NEXC     = 5;
  localparam int unsigned RM_LSB   = 0;
  localparam int unsigned RM_W     = 2;
  localparam int unsigned FLAG_LSB = 2;
  localparam int unsigned EN_LSB   = FLAG_LSB + NEXC;
  localparam int unsigned CAUSE_LSB = EN_LSB + NEXC;
  localparam int unsigned CAUSE_W  = NEXC + 1;
  localparam int unsigned DN_BIT   = CAUSE_LSB + CAUSE_W;
  localparam int unsigned LIVE_W   = DN_BIT + 1;
  localparam logic [WORD_W-1:0] WR_MASK = WORD_W'((64'd1 << LIVE_W) - 64'd1);
  localparam logic [WORD_W-1:0] RST_VAL = WORD_W'(64'd1 << DN_BIT);
  localparam int unsigned VEC_W    = 12;
  localparam logic [VEC_W-1:0] TRAP_VEC = 12'h120;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01
  } rmode_e;

  localparam int unsigned EXC_I = 0;
  localparam int unsigned EXC_U = 1;
  localparam int unsigned EXC_O = 2;
  localparam int unsigned EXC_Z = 3;
  localparam int unsigned EXC_V = 4;
endpackage

// File: rtl/fpsc_cause_gen.sv
module fpsc_cause_gen
  import fpsc_pkg::*;
(
  input  logic [NEXC-1:0] raw_i,
  input  logic            approx_i,
  output logic [NEXC-1:0] cause_o
);
  always_comb begin
    cause_o = '0;
    for (int k = NEXC - 1; k >= 0; k--) begin
      if (raw_i[k]) cause_o[k] = 1'b1;
    end
    if (approx_i && (raw_i == '0)) cause_o[EXC_I] = 1'b1;
  end
endmodule

// File: rtl/fpsc_trap_eval.sv
module fpsc_trap_eval
  import fpsc_pkg::*;
(
  input  logic [NEXC-1:0] cause_i,
  input  logic [NEXC-1:0] enable_i,
  output logic            hit_o
);
  logic [NEXC-1:0] overlap;
  genvar g;
  generate
    for (g = 0; g < NEXC; g++) begin : g_and
      assign overlap[g] = cause_i[g] & enable_i[g];
    end
  endgenerate
  assign hit_o = |overlap;
endmodule

// File: rtl/fpsc_mode_decode.sv
module fpsc_mode_decode
  import fpsc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              trunc_o,
  output logic              ftz_o
);
  rmode_e rm;
  assign rm      = rmode_e'(word_i[RM_LSB +: RM_W]);
  assign trunc_o = (rm == RM_ZERO);
  assign ftz_o   = word_i[DN_BIT];
endmodule

// File: rtl/fpsc_ctrl.sv
module fpsc_ctrl
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              op_done_i,
  input  logic [NEXC-1:0]   op_flags_i,
  input  logic              op_approx_i,
  output logic [WORD_W-1:0] csr_o,
  output logic              rnd_trunc_o,
  output logic              ftz_o,
  output logic              trap_o,
  output logic [VEC_W-1:0]  trap_vec_o
);
  logic [WORD_W-1:0] csr_q, csr_nxt;
  logic [NEXC-1:0]   cause_new;
  logic              hit;
  logic              trap_q;
  logic [VEC_W-1:0]  vec_q;

  fpsc_cause_gen u_cause (
    .raw_i    (op_flags_i),
    .approx_i (op_approx_i),
    .cause_o  (cause_new)
  );

  fpsc_trap_eval u_trap (
    .cause_i  (cause_new),
    .enable_i (csr_q[EN_LSB +: NEXC]),
    .hit_o    (hit)
  );

  fpsc_mode_decode u_mode (
    .word_i  (csr_q),
    .trunc_o (rnd_trunc_o),
    .ftz_o   (ftz_o)
  );

  always_comb begin
    csr_nxt = csr_q;
    csr_nxt[CAUSE_LSB +: CAUSE_W] = {1'b0, cause_new};
    csr_nxt[FLAG_LSB +: NEXC] = csr_q[FLAG_LSB +: NEXC] | cause_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q  <= RST_VAL;
      trap_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      trap_q <= 1'b0;
      vec_q  <= '0;
      if (wr_en_i) begin
        csr_q <= wr_data_i & WR_MASK;
      end else if (op_done_i) begin
        csr_q  <= csr_nxt;
        trap_q <= hit;
        vec_q  <= hit ? TRAP_VEC : '0;
      end
    end
  end

  assign csr_o      = csr_q;
  assign trap_o     = trap_q;
  assign trap_vec_o = vec_q;
endmodule

// File: rtl/fpsc_ctrl_chk.sv
module fpsc_ctrl_chk
  import fpsc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              op_done_i,
  input logic [NEXC-1:0]   op_flags_i,
  input logic              op_approx_i,
  input logic [WORD_W-1:0] csr_o,
  input logic              trap_o,
  input logic [VEC_W-1:0]  trap_vec_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (csr_o[WORD_W-1:LIVE_W] == '0));

  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (csr_o == $past(wr_data_i & WR_MASK)));

  p_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (op_done_i && !wr_en_i && (op_flags_i != '0))
      |=> (csr_o[CAUSE_LSB +: CAUSE_W] == {1'b0, $past(op_flags_i)}));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && op_done_i && !wr_en_i)
      |=> ((csr_o[FLAG_LSB +: NEXC] & $past(csr_o[FLAG_LSB +: NEXC]))
           == $past(csr_o[FLAG_LSB +: NEXC])));

  p_trap_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ((csr_o[CAUSE_LSB +: NEXC] & csr_o[EN_LSB +: NEXC]) != '0));

  p_trap_vec_r7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (trap_vec_o == TRAP_VEC));

  p_approx_r8: assert property (@(posedge clk) disable iff (rst)
    (op_done_i && !wr_en_i && op_approx_i && (op_flags_i == '0))
      |=> csr_o[CAUSE_LSB + EXC_I]);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && op_done_i) |=> !trap_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && !wr_en_i && !op_done_i) |=> $stable(csr_o));
endmodule

bind fpsc_ctrl fpsc_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .op_done_i   (op_done_i),
  .op_flags_i  (op_flags_i),
  .op_approx_i (op_approx_i),
  .csr_o       (csr_o),
  .trap_o      (trap_o),
  .trap_vec_o  (trap_vec_o)
);

// File: tb/fpsc_ctrl_tb.sv
module fpsc_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        op_done;
  logic [4:0]  op_flags;
  logic        op_approx;
  logic [31:0] csr;
  logic        trunc, ftz, trap;
  logic [11:0] vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpsc_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .op_done_i(op_done), .op_flags_i(op_flags), .op_approx_i(op_approx),
    .csr_o(csr), .rnd_trunc_o(trunc), .ftz_o(ftz),
    .trap_o(trap), .trap_vec_o(vec)
  );

  typedef struct {
    logic [31:0] csr;
    logic        trunc;
    logic        ftz;
    logic        trap;
    logic [11:0] vec;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] model = 32'h0004_0000;
  bit          done_run = 0;

  task automatic step(input logic w, input logic [31:0] d, input logic od,
                      input logic [4:0] f, input logic ap, input string tag);
    exp_t e;
    logic [4:0] c;
    logic t;
    @(negedge clk);
    wr_en = w; wr_data = d; op_done = od; op_flags = f; op_approx = ap;
    t = 1'b0;
    if (w) begin
      model = d & 32'h0007_FFFF;
    end else if (od) begin
      c = f;
      if (ap && f == 5'd0) c = 5'b00001;
      model[17:12] = {1'b0, c};
      model[6:2]   = model[6:2] | c;
      t = |(c & model[11:7]);
    end
    e.csr = model; e.trunc = (model[1:0] == 2'b01); e.ftz = model[18];
    e.trap = t; e.vec = t ? 12'h120 : 12'h000; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 1'b0, 5'd0, 1'b0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (csr !== e.csr || trunc !== e.trunc || ftz !== e.ftz ||
            trap !== e.trap || vec !== e.vec) begin
          errors++;
          $display("FAIL %s: csr=%h trunc=%b ftz=%b trap=%b vec=%h expected csr=%h trunc=%b ftz=%b trap=%b vec=%h",
                   e.tag, csr, trunc, ftz, trap, vec, e.csr, e.trunc, e.ftz, e.trap, e.vec);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst = 1'b1; wr_en = 0; wr_data = 0; op_done = 0; op_flags = 0; op_approx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle("R1 reset value");
    idle("R10 hold while idle");
    step(1, 32'hFFFF_FFFF, 0, 5'd0, 0, "R2 masked write, R3 code 11 is nearest");
    step(1, 32'h0000_0001, 0, 5'd0, 0, "R3 code 01 truncates, R4 ftz low");
    step(1, 32'h0004_0002, 0, 5'd0, 0, "R3 code 10 is nearest, R4 ftz high");
    step(1, 32'h0000_0000, 0, 5'd0, 0, "R2 clear word");
    step(0, 32'h0, 1, 5'b00001, 0, "R5 inexact cause");
    step(0, 32'h0, 1, 5'b10100, 0, "R6 causes replaced, flags accumulate");
    step(0, 32'h0, 1, 5'b00000, 1, "R8 approximation forces inexact");
    step(0, 32'h0, 1, 5'b01000, 1, "R8 raised flag takes precedence");
    step(1, 32'h0002_0200, 0, 5'd0, 0, "R2 enable overflow with error cause bit");
    step(0, 32'h0, 1, 5'b00100, 0, "R7 overflow trap, R5 error bit cleared");
    idle("R7 trap lasts one cycle");
    step(0, 32'h0, 1, 5'b00010, 0, "R7 no trap on disabled underflow");
    step(0, 32'h0, 1, 5'b00100, 0, "R7 back-to-back trap first");
    step(0, 32'h0, 1, 5'b10101, 0, "R7 back-to-back trap second");
    step(0, 32'h0, 1, 5'b00000, 0, "R5 clean operation clears causes");
    step(1, 32'h0000_0000, 1, 5'b00100, 0, "R9 write wins over enabled flag");
    step(1, 32'h0000_0F83, 0, 5'd0, 0, "R2 all enables, code 11");
    step(1, 32'h0004_0001, 1, 5'b11111, 1, "R9 write clears enables, no trap");
    idle("R10 hold after collision");
    step(0, 32'h0, 1, 5'b00000, 1, "R8 approximation without enable no trap");
    repeat (3) @(negedge clk);
    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule